// File: doc/BRIEF.md
# DMA Channel Control Register

This block is the control register of a single DMA channel. Software writes it through a simple write strobe with a 32-bit data word and reads it back through a combinational read port. The block holds the channel's run state: an enable, a suspend request and a write-only reset command. It also holds seven interrupt-enable bits, a step-mode bit, a link-port select bit and a two-bit priority field.

The hardware side reports channel events as one-cycle pulses on a 7-bit event input. Bit 0 is transfer complete, bit 1 half transfer, bit 2 data transfer error, bit 3 link update error, bit 4 user setting error, bit 5 suspension reached and bit 6 trigger overrun. Each event sets a sticky flag, and a separate write-1-to-clear input clears the flags. Each interrupt request is its flag gated by the matching enable bit. Completion and the error events stop the channel by clearing the enable.

A channel reset command is applied only once the channel is idle, that is disabled, or suspended with the suspension acknowledged. Until then the command is held pending. When the reset is applied, the block emits a one-cycle reset pulse for the datapath and FIFO and clears the enable and suspend bits.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Writing a word with bit 0 = 1 and bit 1 = 0 sets the enable. Writing bit 0 = 0 leaves the enable unchanged. The enable is read back on bit 0.
- R2: An event pulse on bit 0, 2, 3 or 4 of the event input clears the enable on the next clock edge. When such an event coincides with a software write that sets the enable, the enable ends up cleared. Half-transfer, suspension and overrun events leave the enable unchanged.
- R3: Bit 1 is a write-only reset command and always reads as 0. When it is written as 1 while the channel is idle, the reset output is high for exactly one cycle, starting after the write edge. Enable and suspend are then 0, whatever the same write carried in bits 0 and 2.
- R4: A reset command written while the channel is enabled and not suspension-acknowledged produces no reset pulse. The command is held. The reset pulse follows one cycle after the channel becomes idle, either because the enable is cleared or because the suspension event arrives while suspend is set.
- R5: Bit 2 is the suspend bit. A write without the reset command loads bit 2 into it, so 1 requests suspension and 0 resumes. It is read back on bit 2.
- R6: The step-mode bit (bit 16), the link-port bit (bit 17) and the priority field (bits 19:18) are written only while the channel is disabled. While the channel is enabled they keep their values.
- R7: The priority output carries 0 for low priority with low weight, 1 for low with mid weight, 2 for low with high weight, and 3 for high priority. Every value is written and read back unchanged.
- R8: Interrupt-enable bits occupy bits 14:8, in the same order as the events, and may be written at any time. Each event sets a sticky flag. Each interrupt output equals its flag AND its enable. A 1 on the clear input clears the flag, and an event in the same cycle wins over the clear.
- R9: After reset every field, flag, interrupt output and the reset pulse are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| evt | input | 7 | Channel event pulses |
| flag_clr | input | 7 | Write-1-to-clear for event flags |
| ch_en | output | 1 | Channel enabled |
| ch_susp | output | 1 | Suspend requested |
| step_mode | output | 1 | Step mode select |
| link_port | output | 1 | Link-fetch port select |
| prio | output | 2 | Priority level |
| irq_en | output | 7 | Interrupt enables |
| ch_rst | output | 1 | One-cycle channel reset pulse |
| irq | output | 7 | Masked interrupt requests |

## Verification
Some rules are checked by the assertions on every cycle. The enable only rises after a software write that sets it. A stop event always clears the enable. The reset pulse lasts one cycle, only fires from an idle state and leaves enable and suspend cleared. Locked fields stay stable while enabled, and an interrupt stays raised until it is cleared or disabled. Other behaviours can only be shown by the bench's scenarios. These are the deferral of a reset until completion or suspension, the exact cycle of the delayed pulse, the priority values read back, and precedence when an event and a clear, or a set and a stop, share a cycle.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int DW   = 32,
  parameter int NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic [NEVT-1:0] evt,
  input  logic [NEVT-1:0] flag_clr,
  output logic            ch_en,
  output logic            ch_susp,
  output logic            step_mode,
  output logic            link_port,
  output logic [1:0]      prio,
  output logic [NEVT-1:0] irq_en,
  output logic            ch_rst,
  output logic [NEVT-1:0] irq
);
  localparam int B_EN = 0, B_RST = 1, B_SUSP = 2, B_IE = 8, B_STEP = 16, B_PORT = 17, B_PRIO = 18;
  localparam logic [NEVT-1:0] STOP_MASK = NEVT'(7'b0011101);
  localparam int EV_SUSP = 5;

  logic [NEVT-1:0] flags;
  logic susp_ack, rst_pend;

  wire wr_ctl   = wr_en && !wr_data[B_RST];
  wire rst_req  = wr_en && wr_data[B_RST];
  wire idle     = !ch_en || susp_ack;
  wire rst_fire = (rst_req || rst_pend) && idle;
  wire hw_stop  = |(evt & STOP_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en <= 1'b0; ch_susp <= 1'b0; susp_ack <= 1'b0; rst_pend <= 1'b0; ch_rst <= 1'b0;
    end else begin
      ch_rst   <= rst_fire;
      rst_pend <= rst_fire ? 1'b0 : (rst_pend || rst_req);
      if (rst_fire || hw_stop)             ch_en <= 1'b0;
      else if (wr_ctl && wr_data[B_EN])    ch_en <= 1'b1;
      if (rst_fire)                        ch_susp <= 1'b0;
      else if (wr_ctl)                     ch_susp <= wr_data[B_SUSP];
      if (rst_fire || (wr_ctl && !wr_data[B_SUSP]) || !ch_susp) susp_ack <= 1'b0;
      else if (evt[EV_SUSP])               susp_ack <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_mode <= 1'b0; link_port <= 1'b0; prio <= 2'd0; irq_en <= '0;
    end else if (wr_en) begin
      irq_en <= wr_data[B_IE +: NEVT];
      if (!ch_en) begin
        step_mode <= wr_data[B_STEP];
        link_port <= wr_data[B_PORT];
        prio      <= wr_data[B_PRIO +: 2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | evt;
  end

  assign irq = flags & irq_en;

  always_comb begin
    rd_data = '0;
    rd_data[B_EN]          = ch_en;
    rd_data[B_SUSP]        = ch_susp;
    rd_data[B_IE +: NEVT]  = irq_en;
    rd_data[B_STEP]        = step_mode;
    rd_data[B_PORT]        = link_port;
    rd_data[B_PRIO +: 2]   = prio;
  end

  AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en) |-> $past(wr_en && wr_data[B_EN] && !wr_data[B_RST])); // R1
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stop |=> !ch_en); // R2
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |=> !ch_rst); // R3
  AST_RST_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |-> (!ch_en && !ch_susp)); // R3
  AST_RST_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |-> $past(!ch_en || susp_ack)); // R4
  AST_ACK_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_ack) |-> $past(ch_susp && evt[EV_SUSP])); // R5
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en |=> ($stable(prio) && $stable(step_mode) && $stable(link_port))); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq) & ~$past(flag_clr) & irq_en) & ~irq) == '0); // R8
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [6:0] evt = 0, flag_clr = 0, irq_en, irq;
  logic ch_en, ch_susp, step_mode, link_port, ch_rst;
  logic [1:0] prio;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dma_chan_ctrl u0 (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .evt, .flag_clr,
    .ch_en, .ch_susp, .step_mode, .link_port, .prio, .irq_en, .ch_rst, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic ev(input logic [6:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask

  task automatic t_reset_state;
    chk("R9 rd", rd_data, 0);
    chk("R9 irq", {25'd0, irq}, 0);
    chk("R9 rst", {31'd0, ch_rst}, 0);
    chk("R9 prio", {30'd0, prio}, 0);
  endtask

  task automatic t_enable;
    wr(32'h0); chk("R1 zero", {31'd0, ch_en}, 0);
    wr(32'h1); chk("R1 set", rd_data[0], 1);
    wr(32'h0); chk("R1 w0 ignored", {31'd0, ch_en}, 1);
  endtask

  task automatic t_cfg_lock;
    wr(32'h000F_0001);
    chk("R6 locked", {28'd0, prio, link_port, step_mode}, 0);
    ev(7'h01); chk("R2 done", {31'd0, ch_en}, 0);
    wr(32'h000B_0000);
    chk("R6 open", {28'd0, prio, link_port, step_mode}, 4'b1011);
    for (int p = 0; p < 4; p++) begin
      wr(32'(p) << 18);
      chk("R7 prio", {30'd0, prio}, 32'(p));
      chk("R7 rd", {30'd0, rd_data[19:18]}, 32'(p));
    end
  endtask

  task automatic t_hw_clear;
    logic [6:0] stops [3] = '{7'h04, 7'h08, 7'h10};
    foreach (stops[i]) begin
      wr(32'h1); ev(stops[i]);
      chk("R2 err clear", {31'd0, ch_en}, 0);
    end
    wr(32'h1); ev(7'h02); chk("R2 ht keeps", {31'd0, ch_en}, 1);
    ev(7'h40); chk("R2 to keeps", {31'd0, ch_en}, 1);
    ev(7'h01);
    @(negedge clk); wr_en = 1; wr_data = 32'h1; evt = 7'h01;
    @(negedge clk); wr_en = 0; wr_data = 0; evt = 0;
    chk("R2 stop wins", {31'd0, ch_en}, 0);
  endtask

  task automatic t_reset_idle;
    wr(32'h7);
    chk("R3 pulse", {31'd0, ch_rst}, 1);
    chk("R3 en/susp", {30'd0, ch_en, ch_susp}, 0);
    chk("R3 rd bit1", {31'd0, rd_data[1]}, 0);
    @(negedge clk); chk("R3 one cycle", {31'd0, ch_rst}, 0);
  endtask

  task automatic t_reset_pending;
    wr(32'h1); wr(32'h2);
    chk("R4 no pulse", {30'd0, ch_rst, ch_en}, 1);
    repeat (3) @(negedge clk);
    chk("R4 held", {31'd0, ch_rst}, 0);
    ev(7'h01);
    chk("R4 not yet", {31'd0, ch_rst}, 0);
    @(negedge clk); chk("R4 after done", {31'd0, ch_rst}, 1);
    wr(32'h5); chk("R5 susp", {30'd0, rd_data[2], rd_data[0]}, 3);
    wr(32'h2); chk("R4 susp pending", {30'd0, ch_rst, ch_susp}, 1);
    ev(7'h20); chk("R4 ack wait", {31'd0, ch_rst}, 0);
    @(negedge clk);
    chk("R4 after ack", {29'd0, ch_rst, ch_en, ch_susp}, 3'b100);
    wr(32'h5); wr(32'h1);
    chk("R5 resume", {30'd0, ch_susp, ch_en}, 1);
    ev(7'h01);
  endtask

  task automatic t_irq;
    @(negedge clk); flag_clr = 7'h7F; @(negedge clk); flag_clr = 0;
    ev(7'h02); chk("R8 masked", {25'd0, irq}, 0);
    wr(32'h0000_0200); chk("R8 sticky", {25'd0, irq}, 32'h02);
    @(negedge clk); flag_clr = 7'h02; @(negedge clk); flag_clr = 0;
    chk("R8 clear", {25'd0, irq}, 0);
    @(negedge clk); flag_clr = 7'h02; evt = 7'h02;
    @(negedge clk); flag_clr = 0; evt = 0;
    chk("R8 evt wins", {25'd0, irq}, 32'h02);
  endtask

  initial begin
    #60000;
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    t_enable();
    t_cfg_lock();
    t_hw_clear();
    t_reset_idle();
    t_reset_pending();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule